// File: doc/BRIEF.md
# Counter Loop Branch Unit

This block carries out one step of a counted loop: it reads a register, optionally moves it one step down or up, decides from the new value whether to branch, and hands back both the new register value and the next program counter. All the instruction-specific information arrives in a single control byte, the postbyte. That byte holds the operation, the branch sense, the sign of the branch offset and the register number. A second byte carries the low eight bits of the branch offset.

The sequencer pulses `start_i` for one cycle and presents the postbyte, the offset byte and the program counter as it stands after the offset byte was fetched. In that same cycle the block drives the register number on `rf_rd_sel_o` and samples the register file's combinational answer on `rf_rd_data_i`. One cycle later `done_o` pulses. Alongside it come the write-back strobe with its register number and data, the branch-taken flag, and the next program counter. These are plain control pins with no back-pressure. The caller must use the results in the `done_o` cycle or latch them.

Top module: `loop_branch_unit`

## Requirements
- R1: Postbyte bits 7:6 pick the step applied to the source value: 00 adds -1, 01 adds 0 (test only), 10 adds +1. The arithmetic is 16-bit and wraps modulo 2^16.
- R2: Postbyte bit 5 picks the branch sense. When it is 0 the branch is taken if the 16-bit post-step value is zero. When it is 1 the branch is taken if that value is non-zero.
- R3: Postbyte bit 4 is the sign of a 9-bit offset. When it is set, the offset byte is extended with 8'hFF; otherwise it is extended with 8'h00. The branch target is `pc_i` plus the extended offset, modulo 2^16.
- R4: In the `done_o` cycle, `pc_o` equals the branch target when `taken_o` is 1, and equals the `pc_i` of the launching cycle otherwise.
- R5: Postbyte bits 2:0 select the register. Registers 0, 1 and 2 are 8 bits wide, and 3 to 7 are 16 bits wide. The same number is driven on `rf_rd_sel_o` during the start cycle and on `wb_sel_o` in the done cycle.
- R6: For registers 0 to 2, the upper byte of `rf_rd_data_i` is ignored (taken as zero). The zero test uses the full 16-bit post-step value, so 8'hFF plus one counts as non-zero. `wb_data_o` carries only the low byte, with its upper byte at zero.
- R7: For a legal operation, `wb_en_o` pulses in the done cycle with the post-step value, whether or not the branch is taken.
- R8: Code 11 in bits 7:6 is illegal. The block pulses `illegal_o` in the done cycle, keeps `wb_en_o` and `taken_o` low, and returns `pc_o` equal to `pc_i`.
- R9: Postbyte bit 3 has no effect on any output.
- R10: `done_o` pulses exactly one cycle after each `start_i` cycle and never at any other time.
- R11: After reset, `done_o`, `illegal_o`, `wb_en_o`, `taken_o`, `wb_sel_o`, `wb_data_o` and `pc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle launch strobe |
| postbyte_i | input | 8 | Operation, sense, offset sign and register number |
| offset_i | input | 8 | Low byte of the branch offset |
| pc_i | input | 16 | Program counter after the offset byte |
| rf_rd_sel_o | output | 3 | Register-file read select |
| rf_rd_data_i | input | 16 | Register-file read data, combinational |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Illegal-operation pulse |
| wb_en_o | output | 1 | Write-back strobe |
| wb_sel_o | output | 3 | Write-back register number |
| wb_data_o | output | 16 | Write-back value |
| taken_o | output | 1 | Branch taken |
| pc_o | output | 16 | Next program counter |

## Verification
The bench builds the unit with its default 16-bit data path and 8-bit offset. With that build, every one of the 256 postbyte codes can be exercised. Each code is run against eight register values and four offset bytes. This covers every step, both branch senses, both offset signs, every register, the illegal code and bit 3 in both states. The register values include 0, 1, 16'hFFFF and byte-wrap values such as 16'h12FF. These make visible the zero-crossing corners and the rule that 8-bit registers ignore their upper byte.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  localparam int PB_W  = 8;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    OP_DEC = 2'b00,
    OP_TST = 2'b01,
    OP_INC = 2'b10,
    OP_BAD = 2'b11
  } lbu_op_e;

  typedef struct packed {
    lbu_op_e          op;
    logic             nz_sense;
    logic             neg_off;
    logic [SEL_W-1:0] sel;
  } lbu_dec_t;

endpackage

// File: rtl/lbu_decode.sv
module lbu_decode
  import lbu_pkg::*;
(
  input  logic [PB_W-1:0] postbyte,
  output lbu_dec_t        dec
);

  // Bit 3 carries no meaning for this operation.
  logic unused_pb3;
  assign unused_pb3 = postbyte[3];

  always_comb begin
    dec.op       = lbu_op_e'(postbyte[7:6]);
    dec.nz_sense = postbyte[5];
    dec.neg_off  = postbyte[4];
    dec.sel      = postbyte[SEL_W-1:0];
  end

endmodule

// File: rtl/lbu_count.sv
module lbu_count
  import lbu_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NARROW_W   = 8,
  parameter int NARROW_CNT = 3
) (
  input  lbu_op_e          op,
  input  logic [SEL_W-1:0] sel,
  input  logic             nz_sense,
  input  logic [DATA_W-1:0] src_raw,
  output logic [DATA_W-1:0] wb_value,
  output logic             taken
);

  localparam logic [DATA_W-1:0] LOW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              narrow;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] sum;

  assign narrow = (int'(sel) < NARROW_CNT);
  assign src    = narrow ? (src_raw & LOW_MASK) : src_raw;

  always_comb begin
    unique case (op)
      OP_DEC:  step = '1;
      OP_INC:  step = ONE;
      default: step = '0;
    endcase
  end

  assign sum      = src + step;
  assign taken    = nz_sense ? (|sum) : ~(|sum);
  assign wb_value = narrow ? (sum & LOW_MASK) : sum;

endmodule

// File: rtl/lbu_target.sv
module lbu_target #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [DATA_W-1:0] pc,
  input  logic [OFF_W-1:0]  off,
  input  logic              neg,
  output logic [DATA_W-1:0] target
);

  localparam int EXT_W = DATA_W - OFF_W;

  logic [DATA_W-1:0] ext_off;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ext_off = {{EXT_W{neg}}, off};
    end else begin : g_noext
      assign ext_off = off[DATA_W-1:0];
    end
  endgenerate

  assign target = pc + ext_off;

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lbu_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int OFF_W      = 8,
  parameter int NARROW_W   = 8,
  parameter int NARROW_CNT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PB_W-1:0]   postbyte_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic [SEL_W-1:0]  rf_rd_sel_o,
  input  logic [DATA_W-1:0] rf_rd_data_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic              wb_en_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              taken_o,
  output logic [DATA_W-1:0] pc_o
);

  lbu_dec_t          dec;
  logic [DATA_W-1:0] new_val;
  logic              cond;
  logic [DATA_W-1:0] target;
  logic              legal;

  lbu_decode u_dec (
    .postbyte (postbyte_i),
    .dec      (dec)
  );

  lbu_count #(
    .DATA_W     (DATA_W),
    .NARROW_W   (NARROW_W),
    .NARROW_CNT (NARROW_CNT)
  ) u_cnt (
    .op       (dec.op),
    .sel      (dec.sel),
    .nz_sense (dec.nz_sense),
    .src_raw  (rf_rd_data_i),
    .wb_value (new_val),
    .taken    (cond)
  );

  lbu_target #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
  ) u_tgt (
    .pc     (pc_i),
    .off    (offset_i),
    .neg    (dec.neg_off),
    .target (target)
  );

  assign rf_rd_sel_o = dec.sel;
  assign legal       = (dec.op != OP_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      wb_en_o   <= 1'b0;
      taken_o   <= 1'b0;
      wb_sel_o  <= '0;
      wb_data_o <= '0;
      pc_o      <= '0;
    end else begin
      done_o    <= start_i;
      illegal_o <= start_i && !legal;
      wb_en_o   <= start_i && legal;
      taken_o   <= start_i && legal && cond;
      if (start_i) begin
        wb_sel_o <= dec.sel;
        pc_o     <= (legal && cond) ? target : pc_i;
        if (legal) wb_data_o <= new_val;
      end
    end
  end

  // R10: a done pulse needs a launch in the cycle before
  a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R10: every launch is answered
  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R8: illegal code gives no write-back and no branch
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!wb_en_o && !taken_o && done_o));
  // R8: illegal only for code 11
  a_r8_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($past(postbyte_i[7:6]) == 2'b11));
  // R7: legal completions always write back
  a_r7_wb_always: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !illegal_o) |-> wb_en_o);
  // R4: not taken returns the incoming PC
  a_r4_pc_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !taken_o) |-> (pc_o == $past(pc_i)));
  // R6: narrow registers write back only their low byte
  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && (int'(wb_sel_o) < NARROW_CNT)) |->
      ((wb_data_o >> NARROW_W) == '0));

endmodule

// File: tb/loop_branch_unit_bench.sv
module loop_branch_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  postbyte_i = '0;
  logic [7:0]  offset_i = '0;
  logic [15:0] pc_i = '0;
  logic [2:0]  rf_rd_sel_o;
  logic [15:0] rf_rd_data_i;
  logic        done_o, illegal_o, wb_en_o, taken_o;
  logic [2:0]  wb_sel_o;
  logic [15:0] wb_data_o, pc_o;

  logic [15:0] reg_val = '0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // All registers of the bench's file hold the same value.
  assign rf_rd_data_i = reg_val;

  loop_branch_unit u_loop_branch_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .postbyte_i   (postbyte_i),
    .offset_i     (offset_i),
    .pc_i         (pc_i),
    .rf_rd_sel_o  (rf_rd_sel_o),
    .rf_rd_data_i (rf_rd_data_i),
    .done_o       (done_o),
    .illegal_o    (illegal_o),
    .wb_en_o      (wb_en_o),
    .wb_sel_o     (wb_sel_o),
    .wb_data_o    (wb_data_o),
    .taken_o      (taken_o),
    .pc_o         (pc_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] pb, input logic [15:0] v,
                        input logic [7:0] off, input logic [15:0] pc);
    logic [1:0]  op;
    logic        narrow;
    logic [15:0] src, res, ext, tgt, exp_wb, exp_pc;
    logic        exp_taken, bad;
    string       tag;
    op     = pb[7:6];
    bad    = (op == 2'b11);
    narrow = (pb[2:0] < 3'd3);
    src    = narrow ? {8'h00, v[7:0]} : v;                       // R6
    res    = src + ((op == 2'b00) ? 16'hFFFF : (op == 2'b10) ? 16'h0001 : 16'h0000); // R1
    exp_taken = !bad && (pb[5] ? (res != 0) : (res == 0));        // R2
    ext    = pb[4] ? {8'hFF, off} : {8'h00, off};                 // R3
    tgt    = pc + ext;
    exp_pc = exp_taken ? tgt : pc;                                // R4
    exp_wb = narrow ? {8'h00, res[7:0]} : res;
    tag    = pb[3] ? "R9" : "R1";

    @(negedge clk);
    postbyte_i = pb; offset_i = off; pc_i = pc; reg_val = v; start_i = 1'b1;
    #1;
    check("R5 rd_sel", {29'd0, rf_rd_sel_o}, {29'd0, pb[2:0]});
    @(negedge clk);
    start_i = 1'b0;
    check("R10 done", {31'd0, done_o}, 32'd1);
    check("R8 illegal", {31'd0, illegal_o}, {31'd0, bad});
    check("R7 wb_en", {31'd0, wb_en_o}, {31'd0, !bad});
    check("R2 taken", {31'd0, taken_o}, {31'd0, exp_taken});
    check(exp_taken ? "R3 target" : "R4 pc", {16'd0, pc_o}, {16'd0, exp_pc});
    if (!bad) begin
      check("R5 wb_sel", {29'd0, wb_sel_o}, {29'd0, pb[2:0]});
      check(narrow ? "R6 wb_data" : tag, {16'd0, wb_data_o}, {16'd0, exp_wb});
    end
    @(negedge clk);
    check("R10 single", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    logic [15:0] vals [8];
    logic [7:0]  offs [4];
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h00FF, 16'h12FF, 16'hAB00, 16'h8000, 16'h7FFF};
    offs = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 done", {31'd0, done_o}, 32'd0);
    check("R11 illegal", {31'd0, illegal_o}, 32'd0);
    check("R11 wb_en", {31'd0, wb_en_o}, 32'd0);
    check("R11 taken", {31'd0, taken_o}, 32'd0);
    check("R11 wb", {13'd0, wb_sel_o, wb_data_o}, 32'd0);
    check("R11 pc", {16'd0, pc_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle", {31'd0, done_o}, 32'd0);
    for (int p = 0; p < 256; p++) begin
      for (int vi = 0; vi < 8; vi++) begin
        for (int oi = 0; oi < 4; oi++) begin
          run_op(8'(p), vals[vi], offs[oi],
                 16'(vi * 16'h2345 + p * 16'h0101 + oi * 16'h3FF1));
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule